// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block decides, once per machine cycle, whether a small 8-bit processor core must break off its instruction stream and call an interrupt service routine, and for which of six request sources. Eight raw request flags come in from the peripherals. Two pairs of them are merged, so that there is one serial source and one second-timer source. The merged flags are captured on a sampling strobe. The capture is evaluated at the polling strobe of the next machine cycle. Each source has its own enable bit, and a global enable gates all of them. A per-source priority bit places the source at the high or the low level.

At the polling point the block gives priority to an enabled high-level request over any low-level one. Within a level a fixed order picks the winner. The block then applies the blocking rules. A call is issued only on the final cycle of an instruction, never while the current instruction is a return-from-interrupt or a write to the enable or priority settings, and never while a service of equal or higher level is in progress. A request that loses out is not remembered. Each call sets the in-service flag of its level. A return-from-interrupt clears the highest flag that is set. The call request, its source index and its level stay valid from one polling edge to the next, so the core can form the vector and push the return address.

Top module: `intpri_ctrl`

## Requirements
- R1: After reset call_req, call_idx, call_hi, ins_hi and ins_lo are all 0, and every source sits at the low level until its src_prio bit is set.
- R2: Source indices are 0 external-0, 1 timer-0, 2 external-1, 3 timer-1, 4 serial, 5 timer-2. Among simultaneous requests of one level the lowest index wins.
- R3: src_prio bit 1 selects the high level and 0 the low level. When eligible requests of both levels are sampled together, the high-level one is called.
- R4: raw_flags bits 0..3 feed sources 0..3 directly. Source 4 is raw bit 4 OR raw bit 5. Source 5 is raw bit 6 OR raw bit 7.
- R5: A source is eligible only when its src_en bit and glob_en are both 1.
- R6: Flags are captured on the clock edge where samp_stb is 1. A polling edge (poll_stb 1) evaluates only the most recent capture, never the live flags.
- R7: No call is issued at a polling edge where instr_last is 0.
- R8: No call is issued at a polling edge where instr_reti or instr_cfg_wr is 1. A request still present at the following polling edge is then called.
- R9: While ins_lo or ins_hi is 1 no low-level call is issued. While ins_hi is 1 no call is issued at all. A high-level request does preempt a low-level service.
- R10: An issued call sets ins_hi (high level) or ins_lo (low level). A polling edge with instr_last and instr_reti both 1 clears ins_hi if it is set, and otherwise clears ins_lo.
- R11: A request that is blocked and is absent from the next capture is dropped and never called.
- R12: call_req, call_idx and call_hi (1 = high level) change only at polling edges. They hold the decision until the next polling edge, and call_idx and call_hi read 0 when no call is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_flags | input | 8 | Raw request flags from the peripherals |
| src_en | input | 6 | Per-source enable bits |
| glob_en | input | 1 | Global interrupt enable |
| src_prio | input | 6 | Per-source level, 1 = high |
| samp_stb | input | 1 | Sampling phase of the machine cycle |
| poll_stb | input | 1 | Polling phase of the machine cycle |
| instr_last | input | 1 | Current cycle is the final cycle of the instruction |
| instr_reti | input | 1 | Current instruction is a return-from-interrupt |
| instr_cfg_wr | input | 1 | Current instruction writes the enable or priority settings |
| call_req | output | 1 | Vector call request, held for one machine cycle |
| call_idx | output | 3 | Index of the called source |
| call_hi | output | 1 | Level of the called source, 1 = high |
| ins_hi | output | 1 | A high-level service is in progress |
| ins_lo | output | 1 | A low-level service is in progress |

## Verification
On every cycle the assertions check the following. A call appears only at a polling edge that is the end of an instruction and not a return or a settings write. The called source is enabled and was sampled. A low-level call never happens while a high-level request is eligible or while any service is in progress. The in-service flags drop highest-first and only on a return. The fixed polling order, the merging of the paired flags, the one-cycle lag between capture and evaluation, and the dropping of a request that went away while blocked can be shown only by the bench's sequences of machine cycles. The bench compares those sequences against its behavioural model.

// File: rtl/intpri_pkg.sv
package intpri_pkg;

    localparam int NUM_SRC = 6;
    localparam int NUM_RAW = 8;
    localparam int NUM_LVL = 2;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int LVL_W   = $clog2(NUM_LVL);

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [NUM_RAW-1:0] raw_vec_t;
    typedef logic [IDX_W-1:0]   src_idx_t;

    typedef enum logic [LVL_W-1:0] {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;

    typedef struct packed {
        logic     valid;
        lvl_e     lvl;
        src_idx_t idx;
    } call_t;

    // Fold the paired peripheral flags onto single sources.
    function automatic src_vec_t merge_raw(input raw_vec_t raw);
        src_vec_t v;
        v[3:0] = raw[3:0];
        v[4]   = raw[4] | raw[5];
        v[5]   = raw[6] | raw[7];
        return v;
    endfunction

    // Lowest-numbered set bit wins.
    function automatic src_idx_t first_set(input src_vec_t v);
        src_idx_t r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = src_idx_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/intpri_sampler.sv
module intpri_sampler
    import intpri_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     samp_stb,
    input  raw_vec_t raw_flags,
    output src_vec_t snap
);

    src_vec_t snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (samp_stb) begin
            snap_q <= merge_raw(raw_flags);
        end
    end

    assign snap = snap_q;

endmodule

// File: rtl/intpri_arbiter.sv
module intpri_arbiter
    import intpri_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t snap,
    input  src_vec_t src_en,
    input  logic     glob_en,
    input  src_vec_t src_prio,
    input  logic     poll_stb,
    input  logic     instr_last,
    input  logic     instr_reti,
    input  logic     instr_cfg_wr,
    input  logic     ins_hi,
    input  logic     ins_lo,
    output call_t    issue
);

    src_vec_t           cand     [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_any;
    src_idx_t           lvl_idx  [NUM_LVL];
    logic               boundary_ok;

    generate
        for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
            if (l == int'(LVL_HI)) begin : g_hi
                assign cand[l] = snap & src_en & src_prio & {NUM_SRC{glob_en}};
            end else begin : g_lo
                assign cand[l] = snap & src_en & ~src_prio & {NUM_SRC{glob_en}};
            end
            assign lvl_any[l] = |cand[l];
            assign lvl_idx[l] = first_set(cand[l]);
        end
    endgenerate

    assign boundary_ok = poll_stb & instr_last & ~instr_reti & ~instr_cfg_wr;

    always_comb begin
        issue = '0;
        if (boundary_ok) begin
            if (lvl_any[LVL_HI] && !ins_hi) begin
                issue.valid = 1'b1;
                issue.lvl   = LVL_HI;
                issue.idx   = lvl_idx[LVL_HI];
            end else if (lvl_any[LVL_LO] && !ins_hi && !ins_lo) begin
                issue.valid = 1'b1;
                issue.lvl   = LVL_LO;
                issue.idx   = lvl_idx[LVL_LO];
            end
        end
    end

    // R5: the called source was sampled and is enabled
    a_r5_issue_enabled: assert property (@(posedge clk) disable iff (rst)
        issue.valid |-> (glob_en && src_en[issue.idx] && snap[issue.idx]));

    // R3: a low-level call never passes over an eligible high-level request
    a_r3_high_first: assert property (@(posedge clk) disable iff (rst)
        (issue.valid && issue.lvl == LVL_LO) |-> ((snap & src_en & src_prio) == '0 || !glob_en));

endmodule

// File: rtl/intpri_service.sv
module intpri_service
    import intpri_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  call_t issue,
    input  logic  poll_stb,
    input  logic  instr_last,
    input  logic  instr_reti,
    output logic  ins_hi,
    output logic  ins_lo
);

    logic [NUM_LVL-1:0] ins_q;
    logic [NUM_LVL-1:0] ins_d;
    logic               ret_now;
    logic               cleared;

    assign ret_now = poll_stb & instr_last & instr_reti;

    always_comb begin
        ins_d   = ins_q;
        cleared = 1'b0;
        if (issue.valid) begin
            ins_d[issue.lvl] = 1'b1;
        end else if (ret_now) begin
            for (int l = NUM_LVL - 1; l >= 0; l--) begin
                if (!cleared && ins_q[l]) begin
                    ins_d[l] = 1'b0;
                    cleared  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_q <= '0;
        end else begin
            ins_q <= ins_d;
        end
    end

    assign ins_hi = ins_q[LVL_HI];
    assign ins_lo = ins_q[LVL_LO];

    // R9: no call into a level that is blocked by nesting
    a_r9_no_equal_nesting: assert property (@(posedge clk) disable iff (rst)
        (issue.valid && issue.lvl == LVL_LO) |-> (ins_q == '0));

    a_r9_high_not_preempted: assert property (@(posedge clk) disable iff (rst)
        issue.valid |-> !ins_q[LVL_HI]);

    // R10: low flag drops only when no high service was open
    a_r10_high_released_first: assert property (@(posedge clk) disable iff (rst)
        $fell(ins_q[LVL_LO]) |-> !$past(ins_q[LVL_HI]));

    // R10: a flag drops only on a return at an instruction end
    a_r10_clear_needs_return: assert property (@(posedge clk) disable iff (rst)
        $fell(ins_q[LVL_HI]) |-> $past(ret_now));

endmodule

// File: rtl/intpri_ctrl.sv
module intpri_ctrl
    import intpri_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_RAW-1:0]  raw_flags,
    input  logic [NUM_SRC-1:0]  src_en,
    input  logic                glob_en,
    input  logic [NUM_SRC-1:0]  src_prio,
    input  logic                samp_stb,
    input  logic                poll_stb,
    input  logic                instr_last,
    input  logic                instr_reti,
    input  logic                instr_cfg_wr,
    output logic                call_req,
    output logic [IDX_W-1:0]    call_idx,
    output logic                call_hi,
    output logic                ins_hi,
    output logic                ins_lo
);

    src_vec_t snap;
    call_t    issue;
    call_t    call_q;

    intpri_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .samp_stb  (samp_stb),
        .raw_flags (raw_flags),
        .snap      (snap)
    );

    intpri_arbiter u_arbiter (
        .clk          (clk),
        .rst          (rst),
        .snap         (snap),
        .src_en       (src_en),
        .glob_en      (glob_en),
        .src_prio     (src_prio),
        .poll_stb     (poll_stb),
        .instr_last   (instr_last),
        .instr_reti   (instr_reti),
        .instr_cfg_wr (instr_cfg_wr),
        .ins_hi       (ins_hi),
        .ins_lo       (ins_lo),
        .issue        (issue)
    );

    intpri_service u_service (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .poll_stb   (poll_stb),
        .instr_last (instr_last),
        .instr_reti (instr_reti),
        .ins_hi     (ins_hi),
        .ins_lo     (ins_lo)
    );

    // One machine cycle of call presentation: reloaded at every polling edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            call_q <= '0;
        end else if (poll_stb) begin
            call_q <= issue;
        end
    end

    assign call_req = call_q.valid;
    assign call_idx = call_q.idx;
    assign call_hi  = (call_q.lvl == LVL_HI);

    // R12: outputs move only at polling edges
    a_r12_stable_between_polls: assert property (@(posedge clk) disable iff (rst)
        (!$past(poll_stb) && !$past(rst)) |-> ($stable(call_req) && $stable(call_idx) && $stable(call_hi)));

    // R7: a new call follows a polling edge at an instruction end
    a_r7_call_needs_last: assert property (@(posedge clk) disable iff (rst)
        ($rose(call_req) && !$past(rst)) |-> $past(poll_stb && instr_last));

    // R8: no call right after a return or a settings write
    a_r8_no_call_on_block: assert property (@(posedge clk) disable iff (rst)
        ($rose(call_req) && !$past(rst)) |-> !$past(instr_reti || instr_cfg_wr));

    // R12: index and level read zero when no call is held
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !call_req |-> (call_idx == '0 && !call_hi));

endmodule

// File: tb/intpri_ctrl_test.sv
module intpri_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] raw_flags;
    logic [5:0] src_en;
    logic       glob_en;
    logic [5:0] src_prio;
    logic       samp_stb;
    logic       poll_stb;
    logic       instr_last;
    logic       instr_reti;
    logic       instr_cfg_wr;
    logic       call_req;
    logic [2:0] call_idx;
    logic       call_hi;
    logic       ins_hi;
    logic       ins_lo;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    intpri_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .raw_flags    (raw_flags),
        .src_en       (src_en),
        .glob_en      (glob_en),
        .src_prio     (src_prio),
        .samp_stb     (samp_stb),
        .poll_stb     (poll_stb),
        .instr_last   (instr_last),
        .instr_reti   (instr_reti),
        .instr_cfg_wr (instr_cfg_wr),
        .call_req     (call_req),
        .call_idx     (call_idx),
        .call_hi      (call_hi),
        .ins_hi       (ins_hi),
        .ins_lo       (ins_lo)
    );

    // Behavioural reference model
    logic [5:0] m_snap;
    bit         m_req, m_hi, m_ih, m_il;
    int         m_idx;

    always @(posedge clk) begin
        bit found;
        bit whi;
        int widx;
        if (rst) begin
            m_snap = 0; m_req = 0; m_idx = 0; m_hi = 0; m_ih = 0; m_il = 0;
        end else begin
            if (poll_stb) begin
                found = 0; whi = 0; widx = 0;
                if (instr_last && !instr_reti && !instr_cfg_wr) begin
                    for (int lvl = 1; lvl >= 0; lvl--) begin
                        for (int s = 0; s < 6; s++) begin
                            if (!found && m_snap[s] && src_en[s] && glob_en &&
                                (int'(src_prio[s]) == lvl) &&
                                (lvl == 1 ? !m_ih : (!m_ih && !m_il))) begin
                                found = 1; whi = (lvl == 1); widx = s;
                            end
                        end
                    end
                end
                m_req = found;
                m_idx = found ? widx : 0;
                m_hi  = found ? whi : 0;
                if (found) begin
                    if (whi) m_ih = 1; else m_il = 1;
                end else if (instr_last && instr_reti) begin
                    if (m_ih) m_ih = 0; else m_il = 0;
                end
            end
            if (samp_stb) begin
                m_snap = {raw_flags[7] | raw_flags[6], raw_flags[5] | raw_flags[4], raw_flags[3:0]};
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (call_req !== m_req || int'(call_idx) != m_idx || call_hi !== m_hi ||
                ins_hi !== m_ih || ins_lo !== m_il) begin
                errors++;
                $display("FAIL model R2 R12: got req=%0b idx=%0d hi=%0b ih=%0b il=%0b exp req=%0b idx=%0d hi=%0b ih=%0b il=%0b",
                         call_req, call_idx, call_hi, ins_hi, ins_lo, m_req, m_idx, m_hi, m_ih, m_il);
            end
        end
    end

    task automatic chk(input bit er, input int ei, input bit eh, input bit eih, input bit eil, input string tag);
        checks++;
        if (call_req !== er || int'(call_idx) != ei || call_hi !== eh || ins_hi !== eih || ins_lo !== eil) begin
            errors++;
            $display("FAIL %s: got req=%0b idx=%0d hi=%0b ih=%0b il=%0b exp req=%0b idx=%0d hi=%0b ih=%0b il=%0b",
                     tag, call_req, call_idx, call_hi, ins_hi, ins_lo, er, ei, eh, eih, eil);
        end
    endtask

    // One machine cycle: poll on the first clock, sample on the third.
    task automatic mc(input logic [7:0] f, input bit last, input bit reti, input bit cfg);
        @(negedge clk);
        raw_flags = f; instr_last = last; instr_reti = reti; instr_cfg_wr = cfg;
        poll_stb = 1;
        @(negedge clk);
        poll_stb = 0;
        @(negedge clk);
        samp_stb = 1;
        @(negedge clk);
        samp_stb = 0;
    endtask

    task automatic ret();
        mc(8'h00, 1, 1, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            finish_run();
        end
    end

    initial begin
        rst = 1; raw_flags = 0; src_en = 6'h3F; glob_en = 1; src_prio = 0;
        samp_stb = 0; poll_stb = 0; instr_last = 0; instr_reti = 0; instr_cfg_wr = 0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(0, 0, 0, 0, 0, "R1 reset state");

        // single low request, then return
        mc(8'h04, 0, 0, 0);
        mc(8'h00, 1, 0, 0);
        chk(1, 2, 0, 0, 1, "R10 call sets low in-service");
        ret();
        chk(0, 0, 0, 0, 0, "R10 return clears low");

        // same-level order
        mc(8'h0A, 0, 0, 0);
        mc(8'h00, 1, 0, 0);
        chk(1, 1, 0, 0, 1, "R2 timer-0 before timer-1");
        ret();

        // level beats order
        src_prio = 6'b100000;
        mc(8'h41, 0, 0, 0);
        mc(8'h00, 1, 0, 0);
        chk(1, 5, 1, 1, 0, "R3 high timer-2 beats low external-0");
        ret();
        chk(0, 0, 0, 0, 0, "R10 return clears high");
        src_prio = 0;

        // merged flags
        mc(8'h20, 0, 0, 0);
        mc(8'h00, 1, 0, 0);
        chk(1, 4, 0, 0, 1, "R4 serial transmit flag");
        ret();
        mc(8'h80, 0, 0, 0);
        mc(8'h00, 1, 0, 0);
        chk(1, 5, 0, 0, 1, "R4 timer-2 external flag");
        ret();

        // enables
        src_en = 6'b111101;
        mc(8'h06, 0, 0, 0);
        mc(8'h00, 1, 0, 0);
        chk(1, 2, 0, 0, 1, "R5 disabled timer-0 skipped");
        ret();
        src_en = 6'h3F; glob_en = 0;
        mc(8'h01, 0, 0, 0);
        mc(8'h00, 1, 0, 0);
        chk(0, 0, 0, 0, 0, "R5 global enable off");
        glob_en = 1;

        // instruction boundary and dropping
        mc(8'h01, 0, 0, 0);
        mc(8'h00, 0, 0, 0);
        chk(0, 0, 0, 0, 0, "R7 not final cycle");
        mc(8'h00, 1, 0, 0);
        chk(0, 0, 0, 0, 0, "R11 vanished request dropped");

        // return and settings write block
        mc(8'h01, 0, 0, 0);
        mc(8'h01, 1, 1, 0);
        chk(0, 0, 0, 0, 0, "R8 return blocks call");
        mc(8'h00, 1, 0, 0);
        chk(1, 0, 0, 0, 1, "R8 call after one more instruction");
        ret();
        mc(8'h02, 0, 0, 0);
        mc(8'h00, 1, 0, 1);
        chk(0, 0, 0, 0, 0, "R8 settings write blocks call");

        // sampling lag
        mc(8'h00, 0, 0, 0);
        mc(8'h01, 1, 0, 0);
        chk(0, 0, 0, 0, 0, "R6 live flag not polled");
        mc(8'h00, 1, 0, 0);
        chk(1, 0, 0, 0, 1, "R6 captured flag polled");

        // nesting
        mc(8'h02, 0, 0, 0);
        mc(8'h00, 1, 0, 0);
        chk(0, 0, 0, 0, 1, "R9 low cannot preempt low");
        src_prio = 6'b001000;
        mc(8'h08, 0, 0, 0);
        mc(8'h00, 1, 0, 0);
        chk(1, 3, 1, 1, 1, "R9 high preempts low");
        mc(8'h00, 0, 0, 0);
        chk(0, 0, 0, 1, 1, "R12 call held one machine cycle");
        src_prio = 6'b001001;
        mc(8'h01, 0, 0, 0);
        mc(8'h00, 1, 0, 0);
        chk(0, 0, 0, 1, 1, "R9 high cannot preempt high");
        ret();
        chk(0, 0, 0, 0, 1, "R10 return clears high first");
        ret();
        chk(0, 0, 0, 0, 0, "R10 second return clears low");
        src_prio = 0;

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule